// File: doc/BRIEF.md
# ECC RAM Fault Injection Unit

This block sits between an error-correcting encoder and a RAM on the write path. It can corrupt one or two bits of a stored codeword on purpose, so that the checking logic downstream can be tested against a known error. Each write carries an address, 32 data bits and 7 check bits. The block treats the write as a 39-bit codeword: data in bits 31:0 and check bits in bits 38:32. When injection is armed and a write hits the programmed target address, the block XORs the codeword with a mask built from two bit-index pointers. The corrupted codeword reaches the RAM port one cycle later.

Software sets the block up through a small register bus with valid/ready handshakes and a one-bit error response. The bus has three registers. The control register at offset 0x0 holds the enable bit (bit 0) and the mode bit (bit 1: 0 = single, 1 = double). The target-address register is at offset 0x4 and uses bits 11:0. The bit-pointer register is at offset 0x8. The bit-pointer register is locked while injection is enabled, and a write that hits the lock is refused with an error.

Top module: `ecc_fault_inject`

## Requirements
- R1: After reset, every register reads 0x00000000 and RAM writes pass through unchanged.
- R2: The bit-pointer register keeps the first pointer in bits 7:0 and the second pointer in bits 23:16. All other bits read as zero.
- R3: A write to the bit-pointer register while control bit 0 is 1 leaves the register unchanged and returns a response with the error bit set to 1.
- R4: A write to the bit-pointer register while control bit 0 is 0 updates the register and returns the error bit set to 0.
- R5: Pointer values 0x00 to 0x1F select data bits 0 to 31. Pointer values 0x20 to 0x26 select check bit (value minus 0x20).
- R6: A pointer value from 0x27 to 0xFF selects no bit and causes no flip.
- R7: In single mode (control bit 1 = 0), only the bit named by the first pointer is inverted.
- R8: In double mode (control bit 1 = 1), the bits named by both pointers are inverted. If both pointers name the same bit, that bit is inverted exactly once.
- R9: Bits are inverted only when control bit 0 is 1 and the write address equals the target-address register. Every other write passes through unchanged.
- R10: The control and target-address registers accept writes at any time with the error bit 0. Reads always succeed with the error bit 0. Unmapped offsets read zero and ignore writes.
- R11: Every RAM write appears at the output exactly one cycle after it is presented, with the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| wr_in_valid | input | 1 | RAM write from the encoder |
| wr_in_addr | input | 12 | RAM write address |
| wr_in_data | input | 32 | Data bits |
| wr_in_ecc | input | 7 | Check bits |
| wr_out_valid | output | 1 | RAM write toward the array |
| wr_out_addr | output | 12 | Forwarded address |
| wr_out_data | output | 32 | Possibly corrupted data bits |
| wr_out_ecc | output | 7 | Possibly corrupted check bits |

## Verification
The bench targets the edges of the pointer map. These are pointers 0x1F, 0x20, 0x26, 0x27 and 0xFF: a decoder off by one would flip a wrong bit or a reserved one. It sets both pointers to the same bit in double mode, where an XOR of two one-hot masks would cancel the flip and leave a clean word. It writes the pointer register while the block is enabled: a missing lock shows up as a changed readback or a missing error bit. Random writes that hit and miss the target address, mixed with random mode and pointer settings, expose a block that corrupts the wrong address, or corrupts anything while disabled.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int DATA_W  = 32;
  localparam int ECC_W   = 7;
  localparam int CW_W    = DATA_W + ECC_W;
  localparam int PTR_W   = 8;
  localparam int RAM_AW  = 12;
  localparam int BUS_AW  = 4;
  localparam int BUS_DW  = 32;
  localparam int P2_LSB  = 16;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [BUS_AW-1:0] OFS_TGT  = 4'h4;
  localparam logic [BUS_AW-1:0] OFS_PTR  = 4'h8;

  typedef struct packed {
    logic mode_dbl;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/fi_regs.sv
module fi_regs
  import fi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BUS_DW-1:0] rsp_rdata,
  output ctrl_t             ctrl,
  output logic [RAM_AW-1:0] tgt_addr,
  output logic [PTR_W-1:0]  ptr_a,
  output logic [PTR_W-1:0]  ptr_b
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [RAM_AW-1:0] tgt_q, tgt_d;
  logic [PTR_W-1:0]  pa_q, pa_d, pb_q, pb_d;
  logic              rv_d, re_d;
  logic [BUS_DW-1:0] rd_d;
  logic              wr_ctrl, wr_tgt, wr_ptr, ptr_blocked;

  assign wr_ctrl     = bus_valid && bus_write && (bus_addr == OFS_CTRL);
  assign wr_tgt      = bus_valid && bus_write && (bus_addr == OFS_TGT);
  assign wr_ptr      = bus_valid && bus_write && (bus_addr == OFS_PTR);
  assign ptr_blocked = wr_ptr && ctrl_q.en;

  always_comb begin
    ctrl_d = ctrl_q;
    tgt_d  = tgt_q;
    pa_d   = pa_q;
    pb_d   = pb_q;
    if (wr_ctrl) begin
      ctrl_d.en       = bus_wdata[0];
      ctrl_d.mode_dbl = bus_wdata[1];
    end
    if (wr_tgt) tgt_d = bus_wdata[RAM_AW-1:0];
    if (wr_ptr && !ctrl_q.en) begin
      pa_d = bus_wdata[PTR_W-1:0];
      pb_d = bus_wdata[P2_LSB +: PTR_W];
    end
  end

  always_comb begin
    rv_d = bus_valid;
    re_d = ptr_blocked;
    rd_d = '0;
    if (bus_valid && !bus_write) begin
      unique case (bus_addr)
        OFS_CTRL: rd_d[1:0] = {ctrl_q.mode_dbl, ctrl_q.en};
        OFS_TGT:  rd_d[RAM_AW-1:0] = tgt_q;
        OFS_PTR: begin
          rd_d[PTR_W-1:0]         = pa_q;
          rd_d[P2_LSB +: PTR_W]   = pb_q;
        end
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      tgt_q     <= '0;
      pa_q      <= '0;
      pb_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      tgt_q     <= tgt_d;
      pa_q      <= pa_d;
      pb_q      <= pb_d;
      rsp_valid <= rv_d;
      rsp_err   <= re_d;
      rsp_rdata <= rd_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign tgt_addr = tgt_q;
  assign ptr_a    = pa_q;
  assign ptr_b    = pb_q;

  // R3
  ptr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_PTR && ctrl.en)
      |=> ($stable(ptr_a) && $stable(ptr_b) && rsp_err));
  // R4
  ptr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_PTR && !ctrl.en)
      |=> (ptr_a == $past(bus_wdata[7:0]) && !rsp_err));
  // R10
  rsp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);
endmodule

// File: rtl/fi_mask_gen.sv
module fi_mask_gen
  import fi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ptr_a,
  input  logic [PTR_W-1:0] ptr_b,
  input  logic             dbl,
  output logic [CW_W-1:0]  mask
);
  for (genvar i = 0; i < CW_W; i++) begin : g_bit
    localparam logic [PTR_W-1:0] IDX = PTR_W'(i);
    assign mask[i] = (ptr_a == IDX) || (dbl && (ptr_b == IDX));
  end

  // R7
  single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |-> ($countones(mask) <= 1));
  // R8
  double_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask) <= 2);
  // R6
  reserved_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_a >= PTR_W'(CW_W) && (!dbl || ptr_b >= PTR_W'(CW_W))) |-> (mask == '0));
endmodule

// File: rtl/ecc_fault_inject.sv
module ecc_fault_inject
  import fi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BUS_DW-1:0] rsp_rdata,
  input  logic              wr_in_valid,
  input  logic [RAM_AW-1:0] wr_in_addr,
  input  logic [DATA_W-1:0] wr_in_data,
  input  logic [ECC_W-1:0]  wr_in_ecc,
  output logic              wr_out_valid,
  output logic [RAM_AW-1:0] wr_out_addr,
  output logic [DATA_W-1:0] wr_out_data,
  output logic [ECC_W-1:0]  wr_out_ecc
);
  logic [1:0]        rst_sync;
  logic              rst_i_n;
  ctrl_t             ctrl;
  logic [RAM_AW-1:0] tgt_addr;
  logic [PTR_W-1:0]  ptr_a, ptr_b;
  logic [CW_W-1:0]   mask, cw_in, cw_d;
  logic              hit;
  logic              ov_q;
  logic [RAM_AW-1:0] oa_q;
  logic [CW_W-1:0]   cw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n   = rst_sync[1];
  assign bus_ready = 1'b1;

  fi_regs u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .ctrl(ctrl), .tgt_addr(tgt_addr),
    .ptr_a(ptr_a), .ptr_b(ptr_b)
  );

  fi_mask_gen u_mask (
    .clk(clk), .rst_n(rst_i_n), .ptr_a(ptr_a), .ptr_b(ptr_b),
    .dbl(ctrl.mode_dbl), .mask(mask)
  );

  assign cw_in = {wr_in_ecc, wr_in_data};
  assign hit   = ctrl.en && (wr_in_addr == tgt_addr);

  always_comb begin
    cw_d = cw_in;
    if (hit) cw_d = cw_in ^ mask;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ov_q <= 1'b0;
      oa_q <= '0;
      cw_q <= '0;
    end else begin
      ov_q <= wr_in_valid;
      if (wr_in_valid) begin
        oa_q <= wr_in_addr;
        cw_q <= cw_d;
      end
    end
  end

  assign wr_out_valid = ov_q;
  assign wr_out_addr  = oa_q;
  assign wr_out_data  = cw_q[DATA_W-1:0];
  assign wr_out_ecc   = cw_q[CW_W-1:DATA_W];

  // R9
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_in_valid && !(ctrl.en && wr_in_addr == tgt_addr))
      |=> (wr_out_data == $past(wr_in_data) && wr_out_ecc == $past(wr_in_ecc)));
  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_in_valid |=> (wr_out_valid && wr_out_addr == $past(wr_in_addr)));
endmodule

// File: tb/test_ecc_fault_inject.sv
module test_ecc_fault_inject;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        wi_v = 1'b0;
  logic [11:0] wi_a = '0;
  logic [31:0] wi_d = '0;
  logic [6:0]  wi_e = '0;
  logic        wo_v;
  logic [11:0] wo_a;
  logic [31:0] wo_d;
  logic [6:0]  wo_e;
  int checks = 0, errors = 0;
  logic        m_en, m_dbl;
  logic [11:0] m_tgt;
  logic [7:0]  m_pa, m_pb;

  always #5 clk = ~clk;

  ecc_fault_inject i_ecc_fault_inject (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .wr_in_valid(wi_v), .wr_in_addr(wi_a), .wr_in_data(wi_d), .wr_in_ecc(wi_e),
    .wr_out_valid(wo_v), .wr_out_addr(wo_a), .wr_out_data(wo_d), .wr_out_ecc(wo_e)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     output logic err, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    err = rsp_err; rd = rsp_rdata;
  endtask

  function automatic logic [38:0] model(input logic [11:0] a, input logic [38:0] cw);
    logic [38:0] r = cw;
    if (m_en && a == m_tgt) begin
      if (m_pa < 8'd39) r[m_pa] = ~r[m_pa];
      if (m_dbl && m_pb < 8'd39 && m_pb != m_pa) r[m_pb] = ~r[m_pb];
    end
    return r;
  endfunction

  task automatic cfg(input logic en, input logic dbl, input logic [11:0] t,
                     input logic [7:0] pa, input logic [7:0] pb);
    logic e; logic [31:0] r;
    bus(1'b1, 4'h0, 32'h0, e, r);
    bus(1'b1, 4'h8, {8'h0, pb, 8'h0, pa}, e, r);
    bus(1'b1, 4'h4, {20'h0, t}, e, r);
    bus(1'b1, 4'h0, {30'h0, dbl, en}, e, r);
    m_en = en; m_dbl = dbl; m_tgt = t; m_pa = pa; m_pb = pb;
  endtask

  task automatic ram(input string req, input logic [11:0] a, input logic [31:0] d,
                     input logic [6:0] e);
    logic [38:0] x;
    @(negedge clk);
    wi_v = 1'b1; wi_a = a; wi_d = d; wi_e = e;
    x = model(a, {e, d});
    @(negedge clk);
    wi_v = 1'b0;
    chk(req, {wo_v, wo_a}, {1'b1, a});
    chk(req, {25'h0, wo_e, wo_d}, {25'h0, x});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic e; logic [31:0] r;
    void'($urandom(32'h5eed_1234));
    m_en = 0; m_dbl = 0; m_tgt = 0; m_pa = 0; m_pb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus(1'b0, 4'h0, 0, e, r); chk("R1 ctrl", r, 0);
    bus(1'b0, 4'h4, 0, e, r); chk("R1 tgt", r, 0);
    bus(1'b0, 4'h8, 0, e, r); chk("R1 ptr", r, 0);
    ram("R1 pass", 12'h000, 32'hDEADBEEF, 7'h55);

    // R2 R4 layout and unlocked write
    bus(1'b1, 4'h8, 32'hFFFF_FFFF, e, r); chk("R4 err", e, 0);
    bus(1'b0, 4'h8, 0, e, r); chk("R2 fields", r, 32'h00FF_00FF);
    // R10 unmapped, ctrl/tgt writes
    bus(1'b1, 4'hC, 32'hFFFF_FFFF, e, r); chk("R10 unmapped err", e, 0);
    bus(1'b0, 4'hC, 0, e, r); chk("R10 unmapped read", r, 0);

    // R3 locked pointer
    cfg(1'b1, 1'b0, 12'h123, 8'h05, 8'h07);
    bus(1'b1, 4'h8, 32'h0011_0022, e, r); chk("R3 err", e, 1);
    bus(1'b0, 4'h8, 0, e, r); chk("R3 unchanged", r, 32'h0007_0005);
    bus(1'b1, 4'h4, 32'h0000_0456, e, r); chk("R10 tgt err", e, 0);
    bus(1'b0, 4'h4, 0, e, r); chk("R10 tgt read", r, 32'h456);
    bus(1'b0, 4'h0, 0, e, r); chk("R10 ctrl read", r, 1);

    // R7 single mode, R9 hit/miss
    cfg(1'b1, 1'b0, 12'h0A0, 8'h00, 8'h1F);
    ram("R7 single bit0", 12'h0A0, 32'h0, 7'h0);
    ram("R9 miss", 12'h0A1, 32'h1234_5678, 7'h12);
    cfg(1'b0, 1'b0, 12'h0A0, 8'h00, 8'h1F);
    ram("R9 disabled", 12'h0A0, 32'hFFFF_FFFF, 7'h7F);

    // R5 edges
    cfg(1'b1, 1'b0, 12'h010, 8'h1F, 8'h00); ram("R5 data31", 12'h010, 32'h0, 7'h0);
    cfg(1'b1, 1'b0, 12'h010, 8'h20, 8'h00); ram("R5 ecc0", 12'h010, 32'h0, 7'h0);
    cfg(1'b1, 1'b0, 12'h010, 8'h26, 8'h00); ram("R5 ecc6", 12'h010, 32'h0, 7'h0);
    // R6 reserved
    cfg(1'b1, 1'b1, 12'h010, 8'h27, 8'hFF); ram("R6 reserved", 12'h010, 32'hA5A5_A5A5, 7'h2A);
    // R8 double and same bit
    cfg(1'b1, 1'b1, 12'h020, 8'h03, 8'h22); ram("R8 double", 12'h020, 32'h0, 7'h0);
    cfg(1'b1, 1'b1, 12'h020, 8'h09, 8'h09); ram("R8 same bit", 12'h020, 32'h0, 7'h0);

    // R7 R8 R9 R11 random
    for (int k = 0; k < 40; k++) begin
      logic [11:0] t;
      t = 12'($urandom);
      cfg(1'($urandom), 1'($urandom), t, 8'($urandom % 48), 8'($urandom % 48));
      for (int j = 0; j < 6; j++)
        ram("R11 random", ($urandom % 2) ? t : 12'($urandom), $urandom, 7'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule